// File: doc/BRIEF.md
# Galois Field Power and Logarithm Table Generator

This block fills two lookup RAMs for the field GF(2^m): an antilog table that maps a power i to the field element alpha^i, and a log table that maps a nonzero element back to its power. A single start pulse samples the field degree m. The block then steps a shift-register sequencer once per clock and writes one entry into each table in every active cycle. A decoder elsewhere in the chip reads these tables later. How the tables are used is outside this block.

Each generated antilog value also supplies the address of the matching log entry, so the log table is written as the exact inverse in the same cycle. The feedback taps come from a fixed set of primitive polynomials, one per supported degree from 3 to 14. A degree outside that set raises an error flag and no table is written. The two write ports are plain RAM write strobes. The RAMs accept a write in every cycle, so the block has no back-pressure and no ready input. Control and status pins are plain levels.

Top module: `gf_table_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, busy, done, err, alog_we and log_we are all 0. A reset asserted during a run stops the run and all writes.
- R2: A start seen while not busy samples deg. The supported degrees and their polynomials, written as bits j = coefficient of x^j, are: 3, 4 and 6: 0x0003. 5 and 11: 0x0005. 7 and 10: 0x0009. 8: 0x001D. 9: 0x0011. 12: 0x0053. 13: 0x001B. 14: 0x0443. Any other deg sets err from the next cycle until the next start, leaves done at 0, and causes no write.
- R3: In the first cycle after an accepted start, log_we is 1 with log_addr 0 and log_data 0xFFFF, and alog_we is 0.
- R4: In the following n+1 cycles, where n = 2^m - 1, alog_we is 1 with alog_addr = i for i = 0, 1, ..., n in order. alog_data is 1 << i for i < m, and alog_data is the polynomial word of R2 for i = m.
- R5: For m < i <= n, alog_data is taken from the previous entry p. If bit m-1 of p is set, the value is the polynomial word XOR ((p with bit m-1 cleared) << 1). Otherwise the value is p << 1.
- R6: In each cycle of R4, log_we is 1 with log_addr equal to alog_data and log_data equal to i mod n. The final write is therefore log_data 0 at log_addr 1.
- R7: busy is 1 from the R3 cycle through the last R4 cycle. done rises in the cycle after the last write, with both write enables at 0, and holds until the next start. done and err are never both 1.
- R8: A start while busy is ignored. The run continues with its sampled degree and its timing is unchanged.
- R9: For every supported degree, the value 1 appears on alog_data only at i = 0 and at i = n, so every nonzero element is written exactly once for i < n.
- R10: An accepted start with a supported degree clears err and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when not busy |
| deg | input | 4 | Field degree m, sampled with start |
| alog_we | output | 1 | Antilog table write strobe |
| alog_addr | output | 14 | Antilog table address (power i) |
| alog_data | output | 16 | Antilog table data (element) |
| log_we | output | 1 | Log table write strobe |
| log_addr | output | 14 | Log table address (element) |
| log_data | output | 16 | Log table data (power, 0xFFFF for zero) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Tables complete, held until next start |
| err | output | 1 | Unsupported degree, held until next start |

## Verification
A wrong tap word or a bad shift step shows on alog_data at the first entry that depends on it. That is entry m for the taps and entry m+1 onward for the step, which is within m+2 cycles of start. A corrupted sequencer register then stays wrong for every later entry and often reaches 1 early, which the primitivity check catches. A wrong index counter or end compare shows as an address mismatch in the same cycle, or as done arriving at the wrong cycle. Each degree is checked against a model in the bench that is written from the requirements, entry by entry, including the start-during-run and reset-during-run cases.

// File: rtl/gf_tab_pkg.sv
package gf_tab_pkg;
  localparam int MAX_DEG = 14;
  localparam int MIN_DEG = 3;
  localparam int WORD_W  = 16;
  localparam int DEG_W   = $clog2(MAX_DEG + 2);
  localparam int ADDR_W  = MAX_DEG;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZERO = 2'd1,
    ST_RUN  = 2'd2,
    ST_END  = 2'd3
  } gen_state_e;

  // Packed coefficients of the primitive polynomial (bit j = x^j, x^m dropped)
  function automatic logic [WORD_W-1:0] poly_word(input logic [DEG_W-1:0] m);
    case (m)
      4'd3, 4'd4, 4'd6: poly_word = 16'h0003;
      4'd5, 4'd11:      poly_word = 16'h0005;
      4'd7, 4'd10:      poly_word = 16'h0009;
      4'd8:             poly_word = 16'h001D;
      4'd9:             poly_word = 16'h0011;
      4'd12:            poly_word = 16'h0053;
      4'd13:            poly_word = 16'h001B;
      4'd14:            poly_word = 16'h0443;
      default:          poly_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/gf_tap_sel.sv
module gf_tap_sel
  import gf_tab_pkg::*;
#(
  parameter int DW = DEG_W,
  parameter int WW = WORD_W,
  parameter int MAXD = MAX_DEG,
  parameter int MIND = MIN_DEG
) (
  input  logic [DW-1:0] deg_in,
  output logic [WW-1:0] taps,
  output logic          deg_ok
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw    = poly_word(DEG_W'(deg_in));
    deg_ok = (raw != '0) && (int'(deg_in) >= MIND) && (int'(deg_in) <= MAXD);
    taps   = deg_ok ? WW'(raw) : '0;
  end

  always_comb begin
    if (deg_ok) assert (taps[0] == 1'b1 && (taps >> deg_in) == '0)
      else $error("p_taps_shape_r2: tap word malformed");
  end
endmodule

// File: rtl/gf_seq_ctrl.sv
module gf_seq_ctrl
  import gf_tab_pkg::*;
#(
  parameter int DW = DEG_W,
  parameter int AW = ADDR_W,
  parameter int MAXD = MAX_DEG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  deg_in,
  input  logic           deg_ok,
  output gen_state_e     state,
  output logic [AW-1:0]  idx,
  output logic [AW-1:0]  n_top,
  output logic           launch,
  output logic           step,
  output logic           busy,
  output logic           done,
  output logic           err
);
  localparam logic [AW-1:0] ALL_ONES = '1;

  logic accept;

  assign busy   = (state == ST_ZERO) || (state == ST_RUN);
  assign accept = start && !busy;
  assign launch = accept && deg_ok;
  assign step   = (state == ST_RUN);
  assign done   = (state == ST_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      n_top <= '0;
      err   <= 1'b0;
    end else begin
      if (accept) begin
        if (deg_ok) begin
          state <= ST_ZERO;
          n_top <= ALL_ONES >> (MAXD - int'(deg_in));
          err   <= 1'b0;
        end else begin
          state <= ST_IDLE;
          err   <= 1'b1;
        end
        idx <= '0;
      end else begin
        case (state)
          ST_ZERO: state <= ST_RUN;
          ST_RUN: begin
            if (idx == n_top) state <= ST_END;
            else              idx   <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_RUN) |-> idx == $past(idx) + 1'b1);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && idx != n_top && start) |=> state == ST_RUN);
  p_run_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ZERO) |=> (state == ST_RUN && idx == '0));
endmodule

// File: rtl/gf_lfsr_core.sv
module gf_lfsr_core
  import gf_tab_pkg::*;
#(
  parameter int DW = DEG_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] deg_in,
  input  logic [WW-1:0] taps_in,
  output logic [WW-1:0] cur
);
  localparam logic [WW-1:0] ONE = WW'(1);

  logic [WW-1:0] taps_q;
  logic [WW-1:0] msb_q;
  logic [WW-1:0] nxt;

  always_comb begin
    if ((cur & msb_q) != '0) nxt = taps_q ^ ((cur & ~msb_q) << 1);
    else                     nxt = cur << 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= ONE;
      taps_q <= '0;
      msb_q  <= '0;
    end else if (load) begin
      cur    <= ONE;
      taps_q <= taps_in;
      msb_q  <= ONE << (deg_in - DW'(1));
    end else if (step) begin
      cur <= nxt;
    end
  end

  p_never_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cur != '0);
  p_load_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == ONE);
  p_in_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur & ~((msb_q << 1) - ONE)) == '0);
endmodule

// File: rtl/gf_table_gen.sv
module gf_table_gen
  import gf_tab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DEG_W-1:0]  deg,
  output logic              alog_we,
  output logic [ADDR_W-1:0] alog_addr,
  output logic [WORD_W-1:0] alog_data,
  output logic              log_we,
  output logic [ADDR_W-1:0] log_addr,
  output logic [WORD_W-1:0] log_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [WORD_W-1:0] taps;
  logic              deg_ok;
  gen_state_e        state;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] n_top;
  logic              launch;
  logic              step;
  logic [WORD_W-1:0] cur;

  gf_tap_sel u_tap (
    .deg_in (deg),
    .taps   (taps),
    .deg_ok (deg_ok)
  );

  gf_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .deg_in (deg),
    .deg_ok (deg_ok),
    .state  (state),
    .idx    (idx),
    .n_top  (n_top),
    .launch (launch),
    .step   (step),
    .busy   (busy),
    .done   (done),
    .err    (err)
  );

  gf_lfsr_core u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .step    (step),
    .deg_in  (deg),
    .taps_in (taps),
    .cur     (cur)
  );

  always_comb begin
    alog_we   = (state == ST_RUN);
    alog_addr = idx;
    alog_data = cur;
    log_we    = (state == ST_RUN) || (state == ST_ZERO);
    if (state == ST_ZERO) begin
      log_addr = '0;
      log_data = '1;
    end else begin
      log_addr = cur[ADDR_W-1:0];
      log_data = (idx == n_top) ? '0 : WORD_W'(idx);
    end
  end

  p_no_write_on_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!alog_we && !log_we));
  p_log_tracks_alog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alog_we |-> (log_we && WORD_W'(log_addr) == alog_data));
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!alog_we && !log_we && !busy));
endmodule

// File: tb/gf_table_gen_bench.sv
module gf_table_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  deg = '0;
  logic        alog_we, log_we, busy, done, err;
  logic [13:0] alog_addr, log_addr;
  logic [15:0] alog_data, log_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gf_table_gen u_gf_table_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .deg(deg),
    .alog_we(alog_we), .alog_addr(alog_addr), .alog_data(alog_data),
    .log_we(log_we), .log_addr(log_addr), .log_data(log_data),
    .busy(busy), .done(done), .err(err)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic        ok;
    logic [15:0] poly;
    logic        poke;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'h0000, 1'b0},
    '{4'd3,  1'b1, 16'h0003, 1'b0},
    '{4'd4,  1'b1, 16'h0003, 1'b0},
    '{4'd5,  1'b1, 16'h0005, 1'b1},
    '{4'd6,  1'b1, 16'h0003, 1'b0},
    '{4'd2,  1'b0, 16'h0000, 1'b0},
    '{4'd7,  1'b1, 16'h0009, 1'b0},
    '{4'd8,  1'b1, 16'h001D, 1'b1},
    '{4'd9,  1'b1, 16'h0011, 1'b0},
    '{4'd10, 1'b1, 16'h0009, 1'b0},
    '{4'd11, 1'b1, 16'h0005, 1'b0},
    '{4'd15, 1'b0, 16'h0000, 1'b0},
    '{4'd12, 1'b1, 16'h0053, 1'b0},
    '{4'd13, 1'b1, 16'h001B, 1'b0},
    '{4'd1,  1'b0, 16'h0000, 1'b0},
    '{4'd14, 1'b1, 16'h0443, 1'b0}
  };

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic apply(input vec_t v);
    int n;
    int e_addr, e_data, e_log, e_one, e_poly, e_low;
    logic [15:0] exp, prev, msb;
    @(negedge clk);
    deg = v.m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!v.ok) begin
      check(err && !done && !busy, "R2", $sformatf("flags m=%0d", v.m),
            {err, done, busy}, 3'b100);
      e_low = 0;
      repeat (6) begin
        @(negedge clk);
        if (alog_we || log_we || !err) e_low++;
      end
      check(e_low == 0, "R2", $sformatf("no writes m=%0d", v.m), e_low, 0);
      return;
    end
    n = (1 << v.m) - 1;
    msb = 16'(1) << (v.m - 1);
    check(log_we && !alog_we && log_addr == 0 && log_data == 16'hFFFF && busy,
          "R3", $sformatf("log zero m=%0d", v.m), log_data, 16'hFFFF);
    check(!err && !done, "R10", $sformatf("flags cleared m=%0d", v.m),
          {err, done}, 0);
    e_addr = 0; e_data = 0; e_log = 0; e_one = 0; e_poly = 0; e_low = 0;
    prev = '0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (v.poke) start = 1'b0;
      if (i < v.m)       exp = 16'(1) << i;
      else if (i == v.m) exp = v.poly;
      else if ((prev & msb) != 0) exp = v.poly ^ ((prev & ~msb) << 1);
      else               exp = prev << 1;
      if (!alog_we || alog_addr != 14'(i) || !busy) e_addr++;
      if (alog_data != exp) begin
        if (i <= v.m) e_low++; else e_data++;
        if (e_data + e_low == 1)
          $display("  first mismatch m=%0d i=%0d got 0x%0h", v.m, i, alog_data);
      end
      if (i == v.m && alog_data != v.poly) e_poly++;
      if (!log_we || log_addr != exp[13:0] || log_data != 16'(i % n)) e_log++;
      if (alog_data == 16'h1 && i != 0 && i != n) e_one++;
      prev = exp;
      if (v.poke && i == 4) begin
        deg = 4'd3;
        start = 1'b1;
      end
    end
    check(e_addr == 0, "R4", $sformatf("addr order m=%0d", v.m), e_addr, 0);
    check(e_low == 0, "R4", $sformatf("low entries m=%0d", v.m), e_low, 0);
    check(e_poly == 0, "R4", $sformatf("poly entry m=%0d", v.m), e_poly, 0);
    check(e_data == 0, "R5", $sformatf("step entries m=%0d", v.m), e_data, 0);
    check(e_log == 0, "R6", $sformatf("log writes m=%0d", v.m), e_log, 0);
    check(e_one == 0, "R9", $sformatf("early one m=%0d", v.m), e_one, 0);
    if (v.poke)
      check(e_addr == 0 && e_data == 0, "R8", $sformatf("start ignored m=%0d", v.m),
            e_addr + e_data, 0);
    @(negedge clk);
    check(done && !busy && !err && !alog_we && !log_we, "R7",
          $sformatf("done m=%0d", v.m), {done, busy, err, alog_we, log_we}, 5'b10000);
    @(negedge clk);
    check(done && !busy, "R7", $sformatf("done held m=%0d", v.m), {done, busy}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !alog_we && !log_we, "R1", "in reset",
          {busy, done, err, alog_we, log_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !alog_we && !log_we, "R1", "after release",
          {busy, done, err, alog_we, log_we}, 0);

    for (int k = 0; k < NV; k++) apply(VECS[k]);

    // Reset in the middle of a run
    @(negedge clk);
    deg = 4'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(busy && alog_we, "R1", "run active before reset", {busy, alog_we}, 2'b11);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !alog_we && !log_we, "R1", "reset mid-run",
          {busy, done, err, alog_we, log_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !alog_we && !log_we, "R1", "stays idle after reset",
          {busy, alog_we, log_we}, 0);

    // Error then recovery
    apply(VECS[11]);
    apply(VECS[1]);
    finish_run();
  end
endmodule